// File: doc/BRIEF.md
# Multi-Mode Iterative CORDIC Engine

This block evaluates the CORDIC recurrences for rotation and vectoring in circular, linear and hyperbolic coordinates. A single shift-and-add iteration engine serves all six combinations. One operation is accepted at a time through a ready/valid handshake. The engine runs a fixed number of micro-rotations and then holds the raw x, y and z results on a ready/valid output until a consumer takes them.

The results carry the natural CORDIC gain of the chosen coordinate system. In circular mode the gain is the product of sqrt(1+2^-2s) over the shifts used. In hyperbolic mode it is the product of sqrt(1-2^-2s). Linear mode has no gain. Function wrappers that scale or reinterpret these outputs sit outside the block. Every data word is two's complement with `FRAC` fractional bits. Angles use the same format. The per-step arctangent and inverse hyperbolic tangent constants are derived from the parameters when the design is elaborated.

Top module: `cordic_engine`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0. An operation is taken in the cycle where `in_valid` and `in_ready` are both 1. `in_ready` returns to 1 in the cycle after the result is consumed (`out_valid` and `out_ready` both 1).
- R2: From acceptance until its result is consumed, `in_ready` stays 0 and `in_valid` is ignored. While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_x`, `out_y` and `out_z` do not change.
- R3: `out_valid` rises exactly ITER clock edges after the accepting edge, so no operation can stall.
- R4: Circular rotation (`in_mode` = 3'b000) returns x = Kc(x0 cos z0 − y0 sin z0) and y = Kc(y0 cos z0 + x0 sin z0), with z driven towards 0. Kc is the product of sqrt(1+2^-2i) for i = 0..ITER-1. The step direction follows the sign of z.
- R5: Circular vectoring (3'b100) returns x = Kc·sqrt(x0²+y0²) and z = z0 + atan(y0/x0), with y driven towards 0 (x0 > 0). The step direction is opposite to the sign of y.
- R6: Linear rotation (3'b001) uses the step constant 2^-i. It leaves x bit-exact unchanged and returns y = y0 + x0·z0 for |z0| < 2.
- R7: Linear vectoring (3'b101) returns z = z0 + y0/x0 for |y0/x0| < 2, and x is bit-exact unchanged.
- R8: Hyperbolic rotation (3'b010) uses the shift sequence 1, 2, 3, 4, 4, 5, …, 13, 13, 14, …, where 4, 13, 40 and so on are used twice. It returns x = Kh(x0 cosh z0 + y0 sinh z0) and y = Kh(y0 cosh z0 + x0 sinh z0). Kh is the product of sqrt(1−2^-2s) over that sequence.
- R9: Hyperbolic vectoring (3'b110) returns x = Kh·sqrt(x0²−y0²) and z = z0 + atanh(y0/x0).
- R10: In circular rotation, negating z0 negates the y result and leaves the x result unchanged, within 2^-20.
- R11: The coordinate code 2'b11 in `in_mode[1:0]` behaves exactly as circular. In the default configuration (32 bits, 29 fraction bits, 16 iterations) the circular and hyperbolic results lie within 3e-4 of the formulas above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Engine idle, operation can be taken |
| in_mode | input | 3 | Bit 2: 1 = vectoring, 0 = rotation; bits 1:0: 00 circular, 01 linear, 10 hyperbolic, 11 circular |
| in_x | input | DW | Initial x, signed, FRAC fraction bits |
| in_y | input | DW | Initial y, signed, FRAC fraction bits |
| in_z | input | DW | Initial z or angle, signed, FRAC fraction bits |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_x | output | DW | Final x |
| out_y | output | DW | Final y |
| out_z | output | DW | Final z |

## Verification
The bench targets the hyperbolic schedule. An engine that skips the repeated shift 4 or 13, or starts at shift 0, either drifts outside tolerance or diverges, because the gain and the reachable angle range no longer match. The linear cases check x bit-exact, which catches a datapath that also updates x in linear mode. The negated-angle pair catches a direction decision that treats a zero or negative z asymmetrically. Holding back `out_ready` while a stray `in_valid` is offered exposes a core that overwrites a pending result or accepts a second operation early. The exact latency count catches an off-by-one in the iteration counter.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  typedef enum logic [1:0] {
    CO_CIRC = 2'b00,
    CO_LIN  = 2'b01,
    CO_HYP  = 2'b10,
    CO_RSV  = 2'b11
  } coord_e;

  // 2^-s as a real number
  function automatic real pow2_neg(input int s);
    real v;
    v = 1.0;
    for (int k = 0; k < s; k++) v = v / 2.0;
    return v;
  endfunction

  // arctangent of 2^-s
  function automatic real atan_p2(input int s);
    real x, term, acc;
    if (s == 0) return 0.78539816339744830962;
    x    = pow2_neg(s);
    term = x;
    acc  = 0.0;
    for (int n = 0; n < 40; n++) begin
      if (n % 2 == 0) acc = acc + term / real'(2 * n + 1);
      else            acc = acc - term / real'(2 * n + 1);
      term = term * x * x;
    end
    return acc;
  endfunction

  // inverse hyperbolic tangent of 2^-s, s >= 1
  function automatic real atanh_p2(input int s);
    real x, term, acc;
    x    = pow2_neg(s);
    term = x;
    acc  = 0.0;
    for (int n = 0; n < 40; n++) begin
      acc  = acc + term / real'(2 * n + 1);
      term = term * x * x;
    end
    return acc;
  endfunction

  // shift used by hyperbolic step k: starts at 1, shifts 4, 13, 40 ... run twice
  function automatic int hyp_shift(input int k);
    int  sh, rep;
    bit  dup;
    sh  = 1;
    rep = 4;
    dup = 1'b0;
    for (int j = 0; j < k; j++) begin
      if (sh == rep && !dup) dup = 1'b1;
      else begin
        if (sh == rep) rep = 3 * rep + 1;
        dup = 1'b0;
        sh  = sh + 1;
      end
    end
    return sh;
  endfunction

  function automatic longint to_fix(input real v, input int frac);
    real sc;
    sc = 1.0;
    for (int k = 0; k < frac; k++) sc = sc * 2.0;
    return longint'(v * sc);
  endfunction

endpackage

// File: rtl/cordic_rom.sv
module cordic_rom
  import cordic_pkg::*;
#(
  parameter int DW   = 32,
  parameter int FRAC = 29,
  parameter int ITER = 16,
  parameter int SW   = (ITER > 1) ? $clog2(ITER) : 1,
  parameter int SHW  = $clog2(DW)
) (
  input  logic [SW-1:0]          step_i,
  input  coord_e                 coord_i,
  output logic [SHW-1:0]         shift_o,
  output logic signed [DW-1:0]   ang_o
);

  logic [SHW-1:0]        hyp_sh [ITER];
  logic signed [DW-1:0]  circ_k [ITER];
  logic signed [DW-1:0]  lin_k  [ITER];
  logic signed [DW-1:0]  hyp_k  [ITER];

  for (genvar g = 0; g < ITER; g++) begin : g_ent
    localparam int     HS = hyp_shift(g);
    localparam longint CK = to_fix(atan_p2(g), FRAC);
    localparam longint LK = to_fix(pow2_neg(g), FRAC);
    localparam longint HK = to_fix(atanh_p2(HS), FRAC);
    assign hyp_sh[g] = SHW'(HS);
    assign circ_k[g] = DW'(CK);
    assign lin_k[g]  = DW'(LK);
    assign hyp_k[g]  = DW'(HK);
  end

  always_comb begin
    case (coord_i)
      CO_HYP: begin
        shift_o = hyp_sh[step_i];
        ang_o   = hyp_k[step_i];
      end
      CO_LIN: begin
        shift_o = SHW'(step_i);
        ang_o   = lin_k[step_i];
      end
      default: begin
        shift_o = SHW'(step_i);
        ang_o   = circ_k[step_i];
      end
    endcase
  end

endmodule

// File: rtl/cordic_stage.sv
module cordic_stage
  import cordic_pkg::*;
#(
  parameter int DW  = 32,
  parameter int SHW = $clog2(DW)
) (
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] y_i,
  input  logic signed [DW-1:0] z_i,
  input  coord_e               coord_i,
  input  logic                 vec_i,
  input  logic [SHW-1:0]       shift_i,
  input  logic signed [DW-1:0] ang_i,
  output logic signed [DW-1:0] x_o,
  output logic signed [DW-1:0] y_o,
  output logic signed [DW-1:0] z_o
);

  logic signed [DW-1:0] xs, ys;
  logic                 up;   // step direction +1

  always_comb begin
    xs = x_i >>> shift_i;
    ys = y_i >>> shift_i;
    // vectoring drives y to zero, rotation drives z to zero
    up = vec_i ? y_i[DW-1] : ~z_i[DW-1];
    if (up) begin
      y_o = y_i + xs;
      z_o = z_i - ang_i;
    end else begin
      y_o = y_i - xs;
      z_o = z_i + ang_i;
    end
    case (coord_i)
      CO_LIN:  x_o = x_i;
      CO_HYP:  x_o = up ? (x_i + ys) : (x_i - ys);
      default: x_o = up ? (x_i - ys) : (x_i + ys);
    endcase
  end

endmodule

// File: rtl/cordic_ctrl.sv
module cordic_ctrl #(
  parameter int ITER = 16,
  parameter int SW   = (ITER > 1) ? $clog2(ITER) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          load_o,
  output logic          run_o,
  output logic [SW-1:0] step_o
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} state_e;

  localparam logic [SW-1:0] LAST = SW'(ITER - 1);

  state_e        state;
  logic [SW-1:0] step;

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_DONE);
  assign load_o    = in_valid && in_ready;
  assign run_o     = (state == ST_RUN);
  assign step_o    = step;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      step  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (in_valid) begin
          state <= ST_RUN;
          step  <= '0;
        end
        ST_RUN: begin
          if (step == LAST) begin
            state <= ST_DONE;
            step  <= '0;
          end else begin
            step <= step + 1'b1;
          end
        end
        ST_DONE: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    load_o |=> !in_ready);

  p_hold_valid_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid);

  p_release_r1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> (in_ready && !out_valid));

endmodule

// File: rtl/cordic_engine.sv
module cordic_engine
  import cordic_pkg::*;
#(
  parameter int DW   = 32,
  parameter int FRAC = 29,
  parameter int ITER = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [2:0]           in_mode,
  input  logic signed [DW-1:0] in_x,
  input  logic signed [DW-1:0] in_y,
  input  logic signed [DW-1:0] in_z,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_x,
  output logic signed [DW-1:0] out_y,
  output logic signed [DW-1:0] out_z
);

  localparam int SW  = (ITER > 1) ? $clog2(ITER) : 1;
  localparam int SHW = $clog2(DW);
  localparam int CW  = $clog2(ITER + 2) + 1;

  logic                 load, run;
  logic [SW-1:0]        step;
  logic [SHW-1:0]       shift;
  logic signed [DW-1:0] ang;
  logic signed [DW-1:0] x_r, y_r, z_r, x_n, y_n, z_n;
  coord_e               coord_r;
  logic                 vec_r;

  cordic_ctrl #(.ITER(ITER), .SW(SW)) u_ctrl (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready),
    .load_o(load), .run_o(run), .step_o(step)
  );

  cordic_rom #(.DW(DW), .FRAC(FRAC), .ITER(ITER), .SW(SW), .SHW(SHW)) u_rom (
    .step_i(step), .coord_i(coord_r), .shift_o(shift), .ang_o(ang)
  );

  cordic_stage #(.DW(DW), .SHW(SHW)) u_stage (
    .x_i(x_r), .y_i(y_r), .z_i(z_r),
    .coord_i(coord_r), .vec_i(vec_r),
    .shift_i(shift), .ang_i(ang),
    .x_o(x_n), .y_o(y_n), .z_o(z_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      x_r     <= '0;
      y_r     <= '0;
      z_r     <= '0;
      coord_r <= CO_CIRC;
      vec_r   <= 1'b0;
    end else if (load) begin
      x_r     <= in_x;
      y_r     <= in_y;
      z_r     <= in_z;
      coord_r <= (in_mode[1:0] == 2'b11) ? CO_CIRC : coord_e'(in_mode[1:0]);
      vec_r   <= in_mode[2];
    end else if (run) begin
      x_r <= x_n;
      y_r <= y_n;
      z_r <= z_n;
    end
  end

  assign out_x = x_r;
  assign out_y = y_r;
  assign out_z = z_r;

  // cycles since acceptance, for the bounded-latency check
  logic [CW-1:0] wait_cnt;
  always_ff @(posedge clk) begin
    if (rst)                            wait_cnt <= '0;
    else if (load)                      wait_cnt <= CW'(1);
    else if (out_valid)                 wait_cnt <= '0;
    else if (wait_cnt != '0)            wait_cnt <= wait_cnt + 1'b1;
  end

  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    (wait_cnt > CW'(ITER)) |-> out_valid);

  p_no_early_r3: assert property (@(posedge clk) disable iff (rst)
    (wait_cnt != '0 && wait_cnt <= CW'(ITER)) |-> !out_valid);

  p_out_stable_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> ($stable(out_x) && $stable(out_y) && $stable(out_z)));

  p_lin_x_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (run && coord_r == CO_LIN) |=> $stable(out_x));

endmodule

// File: tb/cordic_engine_test.sv
module cordic_engine_test;

  localparam int DW   = 32;
  localparam int FRAC = 29;
  localparam int ITER = 16;
  localparam real TOL = 3.0e-4;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic [2:0]           in_mode = 3'b000;
  logic signed [DW-1:0] in_x = '0, in_y = '0, in_z = '0;
  logic                 out_valid;
  logic                 out_ready = 1'b1;
  logic signed [DW-1:0] out_x, out_y, out_z;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  cordic_engine #(.DW(DW), .FRAC(FRAC), .ITER(ITER)) uut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_mode(in_mode),
    .in_x(in_x), .in_y(in_y), .in_z(in_z),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_x(out_x), .out_y(out_y), .out_z(out_z)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL R3 watchdog expired: actual=%0d cycles expected<=20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic real scale();
    real s = 1.0;
    for (int k = 0; k < FRAC; k++) s = s * 2.0;
    return s;
  endfunction

  function automatic logic signed [DW-1:0] fx(input real r);
    return DW'(longint'(r * scale()));
  endfunction

  function automatic real fr(input logic signed [DW-1:0] v);
    return $itor(v) / scale();
  endfunction

  function automatic real gain_c();
    real g = 1.0;
    real p = 1.0;
    for (int i = 0; i < ITER; i++) begin
      g = g * $sqrt(1.0 + p * p);
      p = p / 2.0;
    end
    return g;
  endfunction

  // sequence 1,2,3,4,4,5,..,13,13,14,..; 4, 13 and 40 appear twice
  function automatic real gain_h();
    real g = 1.0;
    int  n = 0;
    for (int s = 1; n < ITER; s++) begin
      for (int r = 0; r < ((s == 4 || s == 13 || s == 40) ? 2 : 1); r++) begin
        if (n < ITER) begin
          g = g * $sqrt(1.0 - $pow(2.0, -2.0 * s));
          n++;
        end
      end
    end
    return g;
  endfunction

  function automatic real cosh_f(input real a);
    return ($exp(a) + $exp(-a)) / 2.0;
  endfunction
  function automatic real sinh_f(input real a);
    return ($exp(a) - $exp(-a)) / 2.0;
  endfunction
  function automatic real atanh_f(input real u);
    return 0.5 * $ln((1.0 + u) / (1.0 - u));
  endfunction

  task automatic chk_real(input string tag, input real act, input real exp, input real tol);
    checks++;
    if (act - exp > tol || exp - act > tol) begin
      errors++;
      $display("FAIL %s: actual=%f expected=%f", tag, act, exp);
    end
  endtask

  task automatic chk_int(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  logic signed [DW-1:0] rx, ry, rz;
  int                   lat;

  task automatic do_op(input logic [2:0] m, input real x, input real y, input real z);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid  = 1'b1;
    in_mode   = m;
    in_x      = fx(x);
    in_y      = fx(y);
    in_z      = fx(z);
    out_ready = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 1000) begin
      @(posedge clk);
      #1 lat++;
    end
    rx = out_x;
    ry = out_y;
    rz = out_z;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk_int("R1 in_ready after reset", in_ready, 1);
    chk_int("R1 out_valid after reset", out_valid, 0);
  endtask

  task automatic t_circ_rot();
    real k = gain_c();
    do_op(3'b000, 1.0, 0.0, 0.5);
    chk_int("R3 latency", lat, ITER);
    chk_int("R1 ready after consume", in_ready, 1);
    chk_real("R4 cos x", fr(rx), k * $cos(0.5), TOL);
    chk_real("R4 sin y", fr(ry), k * $sin(0.5), TOL);
    chk_real("R4 z residue", fr(rz), 0.0, TOL);
    do_op(3'b000, 0.6, 0.3, -1.2);
    chk_real("R4 x general", fr(rx), k * (0.6 * $cos(-1.2) - 0.3 * $sin(-1.2)), TOL);
    chk_real("R4 y general", fr(ry), k * (0.3 * $cos(-1.2) + 0.6 * $sin(-1.2)), TOL);
  endtask

  task automatic t_circ_vec();
    real k = gain_c();
    do_op(3'b100, 0.7, 0.4, 0.1);
    chk_real("R5 magnitude", fr(rx), k * $sqrt(0.49 + 0.16), TOL);
    chk_real("R5 angle", fr(rz), 0.1 + $atan2(0.4, 0.7), TOL);
    chk_real("R5 y residue", fr(ry), 0.0, TOL);
    do_op(3'b100, 0.5, -0.6, 0.0);
    chk_real("R5 negative y angle", fr(rz), $atan2(-0.6, 0.5), TOL);
  endtask

  task automatic t_linear();
    do_op(3'b001, 0.75, 0.1, -1.3);
    chk_int("R6 x unchanged", longint'(rx), longint'(fx(0.75)));
    chk_real("R6 product", fr(ry), 0.1 + 0.75 * -1.3, TOL);
    do_op(3'b101, 0.8, 0.5, 0.25);
    chk_int("R7 x unchanged", longint'(rx), longint'(fx(0.8)));
    chk_real("R7 quotient", fr(rz), 0.25 + 0.5 / 0.8, TOL);
  endtask

  task automatic t_hyper();
    real k = gain_h();
    do_op(3'b010, 1.0, 0.0, 0.6);
    chk_real("R8 cosh x", fr(rx), k * cosh_f(0.6), TOL);
    chk_real("R8 sinh y", fr(ry), k * sinh_f(0.6), TOL);
    do_op(3'b010, 0.5, 0.2, -0.9);
    chk_real("R8 general x", fr(rx), k * (0.5 * cosh_f(-0.9) + 0.2 * sinh_f(-0.9)), TOL);
    do_op(3'b110, 0.9, 0.3, 0.0);
    chk_real("R9 magnitude", fr(rx), k * $sqrt(0.81 - 0.09), TOL);
    chk_real("R9 atanh", fr(rz), atanh_f(0.3 / 0.9), TOL);
  endtask

  task automatic t_symmetry();
    logic signed [DW-1:0] x1, y1;
    do_op(3'b000, 1.0, 0.0, 0.7);
    x1 = rx;
    y1 = ry;
    do_op(3'b000, 1.0, 0.0, -0.7);
    chk_real("R10 sine negated", fr(ry), -fr(y1), 1.0e-6);
    chk_real("R10 cosine even", fr(rx), fr(x1), 1.0e-6);
  endtask

  task automatic t_reserved();
    logic signed [DW-1:0] x1, y1, z1;
    do_op(3'b000, 0.4, 0.2, 0.9);
    x1 = rx; y1 = ry; z1 = rz;
    do_op(3'b011, 0.4, 0.2, 0.9);
    chk_int("R11 reserved x", longint'(rx), longint'(x1));
    chk_int("R11 reserved y", longint'(ry), longint'(y1));
    chk_int("R11 reserved z", longint'(rz), longint'(z1));
  endtask

  task automatic t_backpressure();
    logic signed [DW-1:0] hx, hy, hz;
    int n;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_mode   = 3'b001;
    in_x      = fx(0.5);
    in_y      = fx(0.0);
    in_z      = fx(0.5);
    @(posedge clk);
    #1;
    // stray offer while busy must be ignored
    in_x = fx(0.9);
    in_z = fx(-1.0);
    chk_int("R2 busy in_ready", in_ready, 0);
    n = 0;
    while (!out_valid && n < 1000) begin
      @(posedge clk);
      #1 n++;
    end
    in_valid = 1'b0;
    hx = out_x; hy = out_y; hz = out_z;
    chk_int("R2 waiting in_ready", in_ready, 0);
    repeat (5) @(posedge clk);
    #1;
    chk_int("R2 valid held", out_valid, 1);
    chk_int("R2 x held", longint'(out_x), longint'(hx));
    chk_int("R2 y held", longint'(out_y), longint'(hy));
    chk_int("R2 z held", longint'(out_z), longint'(hz));
    chk_real("R2 stray ignored", fr(hy), 0.25, TOL);
    @(negedge clk);
    out_ready = 1'b1;
    @(posedge clk);
    #1;
    chk_int("R1 ready after release", in_ready, 1);
    chk_int("R1 valid dropped", out_valid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_circ_rot();
    t_circ_vec();
    t_linear();
    t_hyper();
    t_symmetry();
    t_reserved();
    t_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule